// File: doc/BRIEF.md
# Always-On Compare Timer

This block is a 16-bit up-counter that sits in a slow always-on clock domain and is controlled from a bus clock domain. Software starts it, stops it or zeroes it with a single control write. It loads a 16-bit target value and arms a compare function. The flag and the interrupt line go high whenever the armed counter is at or above the target. Any write that halts or zeroes the counter also disarms the compare, so a stale target can never fire against a restarted count.

Control levels cross into the counter domain through two-flop synchronizers. Clear, acknowledge and target-load events cross as toggles. Run status, flag and count come back as one bundle through a toggle handshake, so the bus never sees a torn 16-bit value. Because of that crossing, software confirms a halt by polling the run status, which falls only after the counter has actually stopped.

All pins are plain control and status signals. Writes are one-cycle strobes that are always accepted, so there is no back-pressure. Successive writes that toggle the same event need a few counter-clock cycles between them.

Top module: `aon_cmp_timer`

## Requirements
- R1: After reset, rd_run, rd_arm, rd_flag and irq are 0, and rd_count and rd_cmp read 0.
- R2: While the counter runs, rd_count increases. Once rd_run reads 0, rd_count stays constant. The readback always shows one coherent snapshot of run status, flag and count.
- R3: The running counter goes from 0xFFFF to 0x0000 and keeps counting.
- R4: A control write with ctl_clr=1 zeroes the counter. If ctl_run=1 in the same write, counting restarts from 0. If ctl_run=0, the counter stays at 0.
- R5: A control write with ctl_clr=1 or ctl_run=0 forces rd_arm to 0. Any other control write loads ctl_arm into rd_arm. rd_arm shows the new value one bus cycle after the strobe.
- R6: While armed, a count greater than or equal to the target sets the flag. irq follows the flag.
- R7: A control write with ctl_ack=1 clears the flag unless the armed condition still holds, in which case the flag stays set because a set wins over a clear. A control write with ctl_ack=0 leaves the flag unchanged.
- R8: While disarmed, the flag never sets, even when the count passes the target.
- R9: After a halt write, rd_run still reads 1 on the next bus cycle. It drops to 0 only after the counter domain has stopped counting.
- R10: A write on wr_cmp loads cmp_wdata. rd_cmp returns it one bus cycle later, and the counter domain compares against it once it has been transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| ao_clk | input | 1 | Always-on counter clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_ctrl | input | 1 | Control write strobe |
| ctl_run | input | 1 | 1 = run, 0 = halt |
| ctl_clr | input | 1 | 1 = zero the counter |
| ctl_arm | input | 1 | Compare arm value |
| ctl_ack | input | 1 | 1 = acknowledge the flag |
| wr_cmp | input | 1 | Target write strobe |
| cmp_wdata | input | 16 | Target value |
| rd_run | output | 1 | Run status as seen in the counter domain |
| rd_arm | output | 1 | Compare arm bit |
| rd_flag | output | 1 | Flag, via the snapshot |
| rd_count | output | 16 | Counter snapshot |
| rd_cmp | output | 16 | Target value register |
| irq | output | 1 | Interrupt line, counter domain |

## Verification
The bench walks a table of control writes to prove that halting or clearing always disarms. A design that kept the arm bit would let a stale target fire after a restart. It acknowledges while the count is still above the target and expects the flag to stay set. It also writes an acknowledge of 0 and expects no change. A design that gave the clear priority, or decoded the acknowledge as a level, would drop the flag. It runs the counter through the 0xFFFF wrap with a high target and checks that the flag can be cleared once the count falls below the target. A wrong rollover would either stick at the top or never come back under the target. Finally, it checks that run status still reads 1 right after a halt write, and that the count is frozen once the status drops. A design that reported the bus-side request instead of the counter-domain state would fail this check.

// File: rtl/aoct_pkg.sv
package aoct_pkg;
  typedef struct packed {
    logic run;
    logic clr;
    logic arm;
    logic ack;
  } aoct_ctl_t;
endpackage

// File: rtl/aoct_sync.sv
module aoct_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aoct_bus_regs.sv
module aoct_bus_regs
  import aoct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  aoct_ctl_t    ctl,
  input  logic         wr_cmp,
  input  logic [W-1:0] cmp_wdata,
  output logic         run_q,
  output logic         arm_q,
  output logic         clr_tog,
  output logic         ack_tog,
  output logic         cmp_tog,
  output logic [W-1:0] cmp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      arm_q   <= 1'b0;
      clr_tog <= 1'b0;
      ack_tog <= 1'b0;
      cmp_tog <= 1'b0;
      cmp_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= ctl.run;
        // halting or zeroing disarms in the same write
        arm_q <= ctl.arm & ctl.run & ~ctl.clr;
        if (ctl.clr) clr_tog <= ~clr_tog;
        if (ctl.ack) ack_tog <= ~ack_tog;
      end
      if (wr_cmp) begin
        cmp_q   <= cmp_wdata;
        cmp_tog <= ~cmp_tog;
      end
    end
  end

  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && (ctl.clr || !ctl.run) |=> !arm_q)
    else $error("R5 arm survived halt/clear");

  p_arm_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(arm_q))
    else $error("R5 arm changed without write");

  p_cmp_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> cmp_q == $past(cmp_wdata))
    else $error("R10 target not loaded");
endmodule

// File: rtl/aoct_core.sv
module aoct_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_a,
  input  logic         arm_a,
  input  logic         clr_t,
  input  logic         ack_t,
  input  logic         cmp_t,
  input  logic [W-1:0] cmp_a,
  output logic         run_s,
  output logic [W-1:0] count,
  output logic         flag
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] s;
  logic [2:0]       tog_d;
  logic             arm_s, clr_p, ack_p, cmp_p, hit;
  logic [W-1:0]     cmp_s;

  aoct_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({run_a, arm_a, clr_t, ack_t, cmp_t}),
    .q(s)
  );

  assign run_s = s[4];
  assign arm_s = s[3];
  assign {clr_p, ack_p, cmp_p} = s[2:0] ^ tog_d;
  assign hit = arm_s && (count >= cmp_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d <= '0;
      count <= '0;
      cmp_s <= '0;
      flag  <= 1'b0;
    end else begin
      tog_d <= s[2:0];
      if (clr_p)      count <= '0;
      else if (run_s) count <= count + 1'b1;
      if (cmp_p) cmp_s <= cmp_a;
      flag <= hit | (flag & ~ack_p);
    end
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_s && !clr_p && (count == '1) |=> count == '0)
    else $error("R3 no wrap");

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> count == '0)
    else $error("R4 clear missed");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s && !clr_p |=> $stable(count))
    else $error("R2 halted count moved");

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag)
    else $error("R6 flag not set");

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_p && !hit |=> !flag)
    else $error("R7 ack ignored");

  p_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_s && !flag |=> !flag)
    else $error("R8 flag set while disarmed");
endmodule

// File: rtl/aoct_snap.sv
module aoct_snap #(
  parameter int W = 18
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  logic         src_tog, ack_tog, ack_s, tog_s;
  logic [W-1:0] hold;

  aoct_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk(src_clk), .rst_n(rst_n), .d(ack_tog), .q(ack_s)
  );
  aoct_sync #(.W(1), .STAGES(2)) u_tog_sync (
    .clk(dst_clk), .rst_n(rst_n), .d(src_tog), .q(tog_s)
  );

  // source side: capture a new bundle only after the last one was taken
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      src_tog <= 1'b0;
    end else if (ack_s == src_tog) begin
      hold    <= src;
      src_tog <= ~src_tog;
    end
  end

  // destination side: take the bundle while it is held stable
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      dst     <= '0;
      ack_tog <= 1'b0;
    end else if (tog_s != ack_tog) begin
      dst     <= hold;
      ack_tog <= tog_s;
    end
  end

  p_dst_hold_r9: assert property (@(posedge dst_clk) disable iff (!rst_n)
    tog_s == ack_tog |=> $stable(dst))
    else $error("R9 readback changed outside handshake");
endmodule

// File: rtl/aon_cmp_timer.sv
module aon_cmp_timer
  import aoct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             bus_clk,
  input  logic             ao_clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             ctl_run,
  input  logic             ctl_clr,
  input  logic             ctl_arm,
  input  logic             ctl_ack,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             rd_run,
  output logic             rd_arm,
  output logic             rd_flag,
  output logic [CNT_W-1:0] rd_count,
  output logic [CNT_W-1:0] rd_cmp,
  output logic             irq
);
  localparam int SNAP_W = CNT_W + 2;

  aoct_ctl_t        ctl;
  logic             run_q, clr_tog, ack_tog, cmp_tog;
  logic             run_s, flag;
  logic [CNT_W-1:0] count;
  logic [SNAP_W-1:0] snap;

  assign ctl = '{run: ctl_run, clr: ctl_clr, arm: ctl_arm, ack: ctl_ack};

  aoct_bus_regs #(.W(CNT_W)) u_regs (
    .clk(bus_clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .ctl(ctl),
    .wr_cmp(wr_cmp), .cmp_wdata(cmp_wdata),
    .run_q(run_q), .arm_q(rd_arm),
    .clr_tog(clr_tog), .ack_tog(ack_tog), .cmp_tog(cmp_tog),
    .cmp_q(rd_cmp)
  );

  aoct_core #(.W(CNT_W)) u_core (
    .clk(ao_clk), .rst_n(rst_n),
    .run_a(run_q), .arm_a(rd_arm),
    .clr_t(clr_tog), .ack_t(ack_tog), .cmp_t(cmp_tog),
    .cmp_a(rd_cmp),
    .run_s(run_s), .count(count), .flag(flag)
  );

  aoct_snap #(.W(SNAP_W)) u_snap (
    .src_clk(ao_clk), .dst_clk(bus_clk), .rst_n(rst_n),
    .src({run_s, flag, count}),
    .dst(snap)
  );

  assign {rd_run, rd_flag, rd_count} = snap;
  assign irq = flag;
endmodule

// File: tb/sim_aon_cmp_timer.sv
module sim_aon_cmp_timer;
  logic        bus_clk = 1'b0, ao_clk = 1'b0, rst_n = 1'b0;
  logic        wr_ctrl = 1'b0, ctl_run = 1'b0, ctl_clr = 1'b0, ctl_arm = 1'b0, ctl_ack = 1'b0;
  logic        wr_cmp = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        rd_run, rd_arm, rd_flag, irq;
  logic [15:0] rd_count, rd_cmp;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #10 bus_clk = ~bus_clk;  // 50 MHz
  always #6  ao_clk  = ~ao_clk;

  aon_cmp_timer #(.CNT_W(16)) u0 (
    .bus_clk(bus_clk), .ao_clk(ao_clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .ctl_run(ctl_run), .ctl_clr(ctl_clr),
    .ctl_arm(ctl_arm), .ctl_ack(ctl_ack),
    .wr_cmp(wr_cmp), .cmp_wdata(cmp_wdata),
    .rd_run(rd_run), .rd_arm(rd_arm), .rd_flag(rd_flag),
    .rd_count(rd_count), .rd_cmp(rd_cmp), .irq(irq)
  );

  // {run, clr, arm, expected rd_arm}
  localparam logic [3:0] VEC [6] = '{
    4'b1011, 4'b1100, 4'b0010, 4'b1000, 4'b0110, 4'b1011
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wctl(input logic r, input logic c, input logic a, input logic k);
    ctl_run = r; ctl_clr = c; ctl_arm = a; ctl_ack = k; wr_ctrl = 1'b1;
    @(negedge bus_clk);
    wr_ctrl = 1'b0; ctl_clr = 1'b0; ctl_ack = 1'b0;
  endtask

  task automatic wcmp(input logic [15:0] v);
    cmp_wdata = v; wr_cmp = 1'b1;
    @(negedge bus_clk);
    wr_cmp = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge bus_clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c1, c2;
    logic        seen;
    settle(3);
    rst_n = 1'b1;
    settle(20);
    // R1 reset state
    chk("R1 run", rd_run, 0);
    chk("R1 arm", rd_arm, 0);
    chk("R1 flag", rd_flag, 0);
    chk("R1 count", rd_count, 0);
    chk("R1 cmp", rd_cmp, 0);
    chk("R1 irq", irq, 0);

    // R5 auto-disarm table
    foreach (VEC[i]) begin
      wctl(VEC[i][3], VEC[i][2], VEC[i][1], 1'b0);
      chk("R5 arm", rd_arm, VEC[i][0]);
      settle(4);
    end
    wctl(1'b0, 1'b1, 1'b0, 1'b0);
    settle(40);

    // R2 / R9 run, then halt
    wctl(1'b1, 1'b0, 1'b0, 1'b0);
    settle(40);
    chk("R2 running", rd_run, 1);
    c1 = rd_count;
    settle(20);
    c2 = rd_count;
    chk("R2 count rises", c2 > c1, 1);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 run still 1", rd_run, 1);
    settle(40);
    chk("R9 run drops", rd_run, 0);
    c1 = rd_count;
    settle(30);
    chk("R2 halted count", rd_count, c1);
    chk("R2 halted nonzero", c1 != 0, 1);

    // R4 clear
    wctl(1'b0, 1'b1, 1'b0, 1'b0);
    settle(40);
    chk("R4 zero halted", rd_count, 0);
    wctl(1'b1, 1'b1, 1'b0, 1'b0);
    settle(40);
    chk("R4 restart run", rd_run, 1);
    chk("R4 restart small", (rd_count != 0) && (rd_count < 16'd200), 1);
    wctl(1'b0, 1'b1, 1'b0, 1'b0);
    settle(40);

    // R10 target, R6 flag, R7 ack
    wcmp(16'd100);
    chk("R10 cmp readback", rd_cmp, 16'd100);
    settle(10);
    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    settle(150);
    chk("R6 flag", rd_flag, 1);
    chk("R6 irq", irq, 1);
    wctl(1'b1, 1'b0, 1'b1, 1'b1);
    settle(40);
    chk("R7 set wins", rd_flag, 1);
    wctl(1'b1, 1'b0, 1'b0, 1'b1);
    settle(40);
    chk("R7 ack clears", rd_flag, 0);
    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    settle(40);
    chk("R6 rearm flag", rd_flag, 1);
    wctl(1'b1, 1'b0, 1'b0, 1'b0);
    settle(40);
    chk("R7 ack0 no effect", rd_flag, 1);
    wctl(1'b1, 1'b0, 1'b0, 1'b1);
    settle(40);
    chk("R7 ack clears 2", rd_flag, 0);

    // R8 disarmed, count well above target
    settle(200);
    chk("R8 flag", rd_flag, 0);
    chk("R8 irq", irq, 0);

    // R3 wrap with a high target
    wctl(1'b0, 1'b1, 1'b0, 1'b0);
    settle(40);
    wcmp(16'hFF00);
    settle(10);
    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    seen = 1'b0;
    for (int n = 0; n < 60000 && !seen; n++) begin
      @(negedge bus_clk);
      seen = rd_flag;
    end
    chk("R6 high target flag", seen, 1);
    chk("R6 count at target", rd_count >= 16'hFF00, 1);
    wctl(1'b1, 1'b0, 1'b1, 1'b1);
    settle(8);
    chk("R7 set wins high", rd_flag, 1);
    seen = 1'b0;
    for (int n = 0; n < 5000 && !seen; n++) begin
      @(negedge bus_clk);
      seen = (rd_count < 16'h0100);
    end
    chk("R3 wrap seen", seen, 1);
    chk("R3 still running", rd_run, 1);
    wctl(1'b1, 1'b0, 1'b1, 1'b1);
    settle(20);
    chk("R7 ack after wrap", rd_flag, 0);
    chk("R7 irq after wrap", irq, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule